// File: doc/BRIEF.md
# Double-Frequency Write Serializer

The block turns parallel bytes into a serial double-frequency write stream for a disk head path. Each bit goes out in its own cell. A cell opens with a clock transition and carries a second transition half a cell later when the data bit is 1. A ring of eight cell positions walks through one byte. When the ring is at position zero, the next byte is copied from the input into an internal file data register, and a one-cycle byte request tells the upstream side to present the following byte.

While the write gate is low, no transition is produced and the ring and the file data register are held cleared. When the gate rises, a fresh byte is loaded and writing starts at position zero.

An address-mark mode drops the clock transition in chosen cells, so the pattern cannot appear in ordinary data. The block also checks its own output. It counts the transitions that come back from the write line in each cell, and compares that count with the number the cell should have carried. A mismatch sets a sticky write-data error.

Top module: `fm_write_ser`

## Requirements
- R1: After reset, `wr_pulse_o`, `byte_req_o` and `wr_err_o` are 0 and `ring_pos_o` is 0.
- R2: With the gate high, a cell lasts 16 clocks. On the first edge of a cell, `wr_pulse_o` goes high for exactly one clock (the clock transition). No two pulses are ever on consecutive clocks.
- R3: On the ninth edge of a cell (eight clocks after the clock transition), `wr_pulse_o` goes high for one clock when the cell's data bit is 1. Bit 7 of the loaded byte goes out in ring position 0, and bit 0 goes out in ring position 7.
- R4: On the first edge of ring position 0 (edge 0, 128, 256, ... counted from the gate rise), `byte_i`, `am_mode_i` and `am_omit_i` are captured, and `byte_req_o` is high for the following clock only.
- R5: When `am_mode_i` was 1 at load, the clock transition is left out of each cell carrying byte bit i for which `am_omit_i[i]` is 1. Data transitions are unaffected.
- R6: While `wr_gate_i` is low, `wr_pulse_o` stays 0. The edge after the gate falls clears the ring to position 0. `ring_pos_o` reads p during cell p, and advances one clock before the next cell starts.
- R7: A 2-bit saturating counter counts `wr_sense_i` samples for each cell. The expected count is 1 for the clock transition (0 if it is omitted), plus 1 if the data bit is 1. A mismatch sets `wr_err_o` on the second edge of the following cell. Only cells that are followed by another cell with the gate still high are checked.
- R8: `wr_err_o` is sticky. It holds while the gate is low and is cleared on the first edge after the gate rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, 16 per bit cell |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_gate_i | input | 1 | Write enable; low holds the serializer idle |
| byte_i | input | 8 | Next byte to write |
| am_mode_i | input | 1 | Address-mark mode for the byte being loaded |
| am_omit_i | input | 8 | Bit i set: omit clock in the cell carrying byte bit i |
| wr_sense_i | input | 1 | Transition pulses seen on the write line |
| wr_pulse_o | output | 1 | One-clock transition request to the head driver |
| byte_req_o | output | 1 | One-clock pulse when a byte has been taken |
| ring_pos_o | output | 3 | Current ring position |
| wr_err_o | output | 1 | Sticky write-data error |

## Verification
The assertions assume two things. First, `wr_sense_i` echoes `wr_pulse_o` with no added delay. Second, the gate only changes between clock edges. The stimulus keeps `byte_i` and the address-mark inputs steady at each load edge. It feeds the sense line from the pulse output, and adds or removes a single pulse only in the fault runs. The main sweep loads all 256 byte values back to back, with address-mark mode and omit masks varying per byte. Further runs cover a gate that drops mid-frame, an extra transition and a missing transition.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef logic [1:0] xcnt_t;

  function automatic xcnt_t exp_xitions(input logic omit, input logic dbit);
    return xcnt_t'(!omit) + xcnt_t'(dbit);
  endfunction
endpackage

// File: rtl/fm_cell_timer.sv
module fm_cell_timer #(
  parameter int CELL_CLKS = 16,
  parameter int CELLS     = 8,
  localparam int TW   = $clog2(CELL_CLKS),
  localparam int PW   = $clog2(CELLS),
  localparam int HALF = CELL_CLKS / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  output logic [PW-1:0] pos_o,
  output logic          cell_start_o,
  output logic          mid_o,
  output logic          chk_pt_o,
  output logic          frame_start_o
);
  logic [TW-1:0] tick_q;
  logic [PW-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      pos_q  <= '0;
    end else if (!run_i) begin
      tick_q <= '0;
      pos_q  <= '0;
    end else if (tick_q == TW'(CELL_CLKS - 1)) begin
      tick_q <= '0;
      pos_q  <= (pos_q == PW'(CELLS - 1)) ? '0 : pos_q + 1'b1;
    end else begin
      tick_q <= tick_q + 1'b1;
    end
  end

  assign pos_o         = pos_q;
  assign cell_start_o  = (tick_q == '0);
  assign mid_o         = (tick_q == TW'(HALF));
  assign chk_pt_o      = (tick_q == TW'(1));
  assign frame_start_o = cell_start_o && (pos_q == '0);
endmodule

// File: rtl/fm_fdr.sv
module fm_fdr #(
  parameter int DATA_W = 8,
  localparam int PW = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              am_i,
  input  logic [DATA_W-1:0] omit_i,
  input  logic [PW-1:0]     pos_i,
  output logic              bit_o,
  output logic              omit_o
);
  logic [DATA_W-1:0] fdr_q, omit_q, omit_eff;
  logic [PW-1:0]     idx;

  assign omit_eff = am_i ? omit_i : '0;
  assign idx      = PW'(DATA_W - 1) - pos_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fdr_q  <= '0;
      omit_q <= '0;
    end else if (!run_i) begin
      fdr_q  <= '0;
      omit_q <= '0;
    end else if (load_i) begin
      fdr_q  <= byte_i;
      omit_q <= omit_eff;
    end
  end

  // bypass so the load cell uses the byte being captured
  assign bit_o  = load_i ? byte_i[idx]   : fdr_q[idx];
  assign omit_o = load_i ? omit_eff[idx] : omit_q[idx];
endmodule

// File: rtl/fm_xition_chk.sv
module fm_xition_chk
  import fm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  run_i,
  input  logic  clr_i,
  input  logic  cell_start_i,
  input  logic  chk_pt_i,
  input  xcnt_t exp_i,
  input  logic  sense_i,
  output logic  err_o
);
  xcnt_t cnt_q, exp_cur_q, exp_prev_q;
  logic  armed_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      exp_cur_q  <= '0;
      exp_prev_q <= '0;
      armed_q    <= 1'b0;
      err_q      <= 1'b0;
    end else if (!run_i) begin
      cnt_q      <= '0;
      exp_cur_q  <= '0;
      exp_prev_q <= '0;
      armed_q    <= 1'b0;
    end else begin
      if (clr_i) err_q <= 1'b0;
      if (cell_start_i) begin
        exp_prev_q <= exp_cur_q;
        exp_cur_q  <= exp_i;
      end
      // sample at tick 1 is the first of the new cell's window
      if (chk_pt_i) begin
        if (armed_q && cnt_q != exp_prev_q) err_q <= 1'b1;
        armed_q <= 1'b1;
        cnt_q   <= xcnt_t'(sense_i);
      end else if (sense_i && cnt_q != 2'd3) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/fm_write_ser.sv
module fm_write_ser
  import fm_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CELL_CLKS = 16,
  localparam int PW = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_gate_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              am_mode_i,
  input  logic [DATA_W-1:0] am_omit_i,
  input  logic              wr_sense_i,
  output logic              wr_pulse_o,
  output logic              byte_req_o,
  output logic [PW-1:0]     ring_pos_o,
  output logic              wr_err_o
);
  logic          cell_start, mid, chk_pt, frame_start;
  logic [PW-1:0] pos;
  logic          dbit, omit, gate_q, pulse_c;
  xcnt_t         exp_c;

  fm_cell_timer #(.CELL_CLKS(CELL_CLKS), .CELLS(DATA_W)) u_timer (
    .clk_i, .rst_ni, .run_i(wr_gate_i), .pos_o(pos),
    .cell_start_o(cell_start), .mid_o(mid), .chk_pt_o(chk_pt),
    .frame_start_o(frame_start)
  );

  fm_fdr #(.DATA_W(DATA_W)) u_fdr (
    .clk_i, .rst_ni, .run_i(wr_gate_i), .load_i(frame_start),
    .byte_i, .am_i(am_mode_i), .omit_i(am_omit_i), .pos_i(pos),
    .bit_o(dbit), .omit_o(omit)
  );

  assign exp_c   = exp_xitions(omit, dbit);
  assign pulse_c = wr_gate_i && ((cell_start && !omit) || (mid && dbit));

  fm_xition_chk u_chk (
    .clk_i, .rst_ni, .run_i(wr_gate_i), .clr_i(wr_gate_i && !gate_q),
    .cell_start_i(cell_start), .chk_pt_i(chk_pt), .exp_i(exp_c),
    .sense_i(wr_sense_i), .err_o(wr_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q     <= 1'b0;
      wr_pulse_o <= 1'b0;
      byte_req_o <= 1'b0;
    end else begin
      gate_q     <= wr_gate_i;
      wr_pulse_o <= pulse_c;
      byte_req_o <= wr_gate_i && frame_start;
    end
  end

  assign ring_pos_o = pos;
endmodule

// File: rtl/fm_write_ser_chk.sv
module fm_write_ser_chk #(
  parameter int PW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_gate_i,
  input logic          wr_pulse_o,
  input logic          byte_req_o,
  input logic [PW-1:0] ring_pos_o,
  input logic          wr_err_o
);
  assert_gate_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_gate_i |=> !wr_pulse_o);
  assert_pulse_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse_o |=> !wr_pulse_o);
  assert_req_at_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_req_o |-> ring_pos_o == '0);
  assert_ring_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_gate_i) |=> ring_pos_o == '0);
  assert_err_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_gate_i) |=> !wr_err_o);
endmodule

bind fm_write_ser fm_write_ser_chk #(.PW(PW)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_gate_i(wr_gate_i),
  .wr_pulse_o(wr_pulse_o), .byte_req_o(byte_req_o),
  .ring_pos_o(ring_pos_o), .wr_err_o(wr_err_o)
);

// File: tb/sim_fm_write_ser.sv
`timescale 1ns/1ps
module sim_fm_write_ser;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_gate = 1'b0, am_mode = 1'b0, inject = 1'b0, drop = 1'b0;
  logic [7:0] byte_in = '0, am_omit = '0;
  logic wr_pulse, byte_req, wr_err, wr_sense;
  logic [2:0] ring_pos;
  int total = 0, bad = 0;
  bit done = 0;

  logic [7:0] bq [256];
  logic       amq [256];
  logic [7:0] oq [256];

  always #4 clk = ~clk;
  assign wr_sense = drop ? 1'b0 : (wr_pulse | inject);

  fm_write_ser u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_gate_i(wr_gate), .byte_i(byte_in),
    .am_mode_i(am_mode), .am_omit_i(am_omit), .wr_sense_i(wr_sense),
    .wr_pulse_o(wr_pulse), .byte_req_o(byte_req), .ring_pos_o(ring_pos),
    .wr_err_o(wr_err)
  );

  task automatic chk(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d t=%0t", tag, got, exp, $time);
    end
  endtask

  // run gate for nedge edges; fault edge k (-1 = none)
  task automatic run_gate(int nedge, int inj_k, int drop_k, int err_start);
    for (int n = 0; n < nedge; n++) begin
      int b, c, t, idx, ep, ee;
      @(negedge clk);
      b = n / 128; c = (n / 16) % 8; t = n % 16; idx = 7 - c;
      wr_gate = 1'b1;
      byte_in = bq[b]; am_mode = amq[b]; am_omit = oq[b];
      inject = (n == inj_k); drop = (n == drop_k);
      @(posedge clk); #1;
      ep = ((t == 0 && !(amq[b] && oq[b][idx])) || (t == 8 && bq[b][idx])) ? 1 : 0;
      if (t == 0) chk(amq[b] ? "R5 clock" : "R2 clock", wr_pulse, ep);
      else if (t == 8) chk("R3 data", wr_pulse, ep);
      else chk("R2 idle", wr_pulse, 0);
      chk("R4 byte_req", byte_req, (n % 128 == 0) ? 1 : 0);
      if (t == 4) chk("R6 ring", ring_pos, ((n + 1) / 16) % 8);
      ee = 0;
      if (inj_k >= 0 && n >= 16 * ((inj_k - 1) / 16 + 1) + 1) ee = 1;
      if (drop_k >= 0 && n >= 16 * ((drop_k - 1) / 16 + 1) + 1) ee = 1;
      if (n == 0) chk("R8 clear on rise", wr_err, 0);
      else if (ee == 0 && err_start == 0) chk("R7 no error", wr_err, 0);
      else if (ee == 1) chk("R7 error set", wr_err, 1);
    end
    @(negedge clk);
    wr_gate = 1'b0; inject = 1'b0; drop = 1'b0;
  endtask

  task automatic idle(int ncyc, int exp_err);
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      byte_in = 8'(i * 29 + 1); am_mode = 1'b0; am_omit = 8'(i);
      @(posedge clk); #1;
      chk("R6 gate low quiet", wr_pulse, 0);
      chk("R6 ring cleared", ring_pos, 0);
      chk("R8 err held", wr_err, exp_err);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog got=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pulse", wr_pulse, 0);
    chk("R1 req", byte_req, 0);
    chk("R1 err", wr_err, 0);
    chk("R1 ring", ring_pos, 0);
    @(negedge clk) rst_ni = 1'b1;

    // sweep every byte value, address-mark mode on odd entries
    for (int b = 0; b < 256; b++) begin
      bq[b] = 8'(b); amq[b] = b[0]; oq[b] = 8'(b * 5 + 3);
    end
    run_gate(256 * 128, -1, -1, 0);
    idle(10, 0);

    // abort mid-frame then restart with fresh bytes
    bq[0] = 8'hA5; amq[0] = 1'b1; oq[0] = 8'hFF;
    bq[1] = 8'h3C; amq[1] = 1'b0; oq[1] = 8'hFF;
    run_gate(53, -1, -1, 0);
    idle(5, 0);
    bq[0] = 8'h00; amq[0] = 1'b1; oq[0] = 8'h24;
    run_gate(256, -1, -1, 0);
    idle(4, 0);

    // extra transition in cell 2, sticky across gate low
    bq[0] = 8'h96;
    run_gate(128, 16 * 2 + 5, -1, 0);
    idle(6, 1);

    // missing clock transition of cell 3; err cleared at rise
    bq[0] = 8'h5A; amq[0] = 1'b0;
    run_gate(128, -1, 16 * 3 + 1, 0);
    idle(3, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule